// File: doc/BRIEF.md
# Multicycle Shared-Resource Datapath

This block is the 32-bit datapath of a processor that spreads each instruction over several clock cycles. It does not decide what to do on its own. An external sequencer drives every multiplexer select and every write enable on each cycle. The datapath supports a small load/store set: word load, word store, branch on equality, absolute jump, and register-to-register add, subtract, AND, OR, XOR, NOR and signed set-less-than.

Only one memory port and one arithmetic unit exist. Instruction fetches and data accesses use the same address output. The arithmetic unit computes the next sequential PC, the branch target, the effective address and the operation result, each in a different cycle.

Results pass from one step to the next through holding registers:

- the program counter;
- the instruction register;
- the memory data register;
- two operand latches;
- the result latch.

A 32-entry register file holds the architectural registers. The memory sits outside the block and answers reads combinationally from the address output.

Top module: `mc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the PC, the instruction register and the result latch become zero on that edge.
- R2: `mem_addr` carries the PC when `iord` is 0 and the result latch when `iord` is 1.
- R3: The first ALU operand is the PC when `alu_src_a` is 0 and the first operand latch when it is 1. The second ALU operand depends on `alu_src_b`:
  - 0: the second operand latch;
  - 1: the constant 4;
  - 2: instruction bits 15..0, sign-extended;
  - 3: the same sign-extended value shifted left by two.
- R4: The PC loads on an edge when `pc_write` is 1, or when `pc_write_cond` is 1 and `alu_zero` is 1. Otherwise it holds. The value loaded depends on `pc_source`:
  - 0: the live ALU result;
  - 1: the result latch;
  - 2: PC bits 31..28 followed by instruction bits 25..0 and two zero bits.
- R5: The instruction register loads `mem_rdata` only on edges where `ir_write` is 1. The memory data register, both operand latches and the result latch load on every edge.
- R6: The operand latches read the register file at instruction bits 25..21 (first operand) and 20..16 (second operand). `mem_wdata` always shows the second operand latch.
- R7: When `reg_write` is 1, the register file takes a write at the edge. The destination is instruction bits 15..11 if `reg_dst` is 1, or bits 20..16 if it is 0. The data is the result latch if `mem_to_reg` is 0, or the memory data register if it is 1.
- R8: `alu_op` selects the operation in two levels:
  - 0: add;
  - 1: subtract;
  - 2: decode instruction bits 5..0, where 0x20 is add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x26 XOR, 0x27 NOR and 0x2A set-less-than;
  - 3, or any other function code: add.
- R9: Set-less-than yields 1 or 0 from a signed comparison. `alu_zero` is 1 exactly when the live ALU result is all zeros.
- R10: Register 0 always reads as zero, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_write | input | 1 | Instruction register load enable |
| iord | input | 1 | Memory address select: 0 PC, 1 result latch |
| alu_src_a | input | 1 | First ALU operand select |
| alu_src_b | input | 2 | Second ALU operand select |
| alu_op | input | 2 | Operation class for the ALU decoder |
| pc_source | input | 2 | Next PC select |
| pc_write | input | 1 | Unconditional PC load |
| pc_write_cond | input | 1 | PC load qualified by the zero flag |
| reg_dst | input | 1 | Destination field select |
| mem_to_reg | input | 1 | Write-back data select |
| reg_write | input | 1 | Register file write enable |
| mem_rdata | input | 32 | Read data from the shared memory |
| mem_addr | output | 32 | Byte address to the shared memory |
| mem_wdata | output | 32 | Store data (second operand latch) |
| pc_o | output | 32 | Current program counter |
| ir_o | output | 32 | Current instruction register |
| alu_out_o | output | 32 | Current result latch |
| alu_zero | output | 1 | Live ALU result is zero |

## Verification
The register file is the hardest state to observe, because it has no output of its own. Its contents show up only after a later instruction copies them into an operand latch and then stores them. The stimulus therefore acts as the sequencer. It loads operands with word loads from a data area, runs each register operation, and writes the result back. A store then brings that result out to the memory model, which is read there. The same round trip shows that writes to register 0 are discarded and that a negative load offset is sign-extended.

// File: rtl/mc_pkg.sv
package mc_pkg;

  // Four-bit operation codes presented to the arithmetic unit
  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_XOR = 4'b0010,
    ALU_NOR = 4'b0011,
    ALU_ADD = 4'b0110,
    ALU_SUB = 4'b1110,
    ALU_SLT = 4'b1111
  } alu_ctl_e;

  // Operation class supplied by the sequencer
  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10,
    CLS_RSVD  = 2'b11
  } alu_cls_e;

  // Function codes of the register-register group
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // Operand source selects
  localparam logic [1:0] SRCB_REG   = 2'd0;
  localparam logic [1:0] SRCB_FOUR  = 2'd1;
  localparam logic [1:0] SRCB_IMM   = 2'd2;
  localparam logic [1:0] SRCB_IMMX4 = 2'd3;

  // Next PC selects
  localparam logic [1:0] PCS_LIVE  = 2'd0;
  localparam logic [1:0] PCS_LATCH = 2'd1;
  localparam logic [1:0] PCS_JUMP  = 2'd2;

endpackage

// File: rtl/mc_alu_ctrl.sv
module mc_alu_ctrl
  import mc_pkg::*;
(
  input  logic [1:0] alu_op,
  input  logic [5:0] funct,
  output alu_ctl_e   alu_ctl
);

  alu_ctl_e funct_ctl;

  always_comb begin
    unique case (funct)
      FN_SUB:  funct_ctl = ALU_SUB;
      FN_AND:  funct_ctl = ALU_AND;
      FN_OR:   funct_ctl = ALU_OR;
      FN_XOR:  funct_ctl = ALU_XOR;
      FN_NOR:  funct_ctl = ALU_NOR;
      FN_SLT:  funct_ctl = ALU_SLT;
      default: funct_ctl = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (alu_cls_e'(alu_op))
      CLS_SUB:   alu_ctl = ALU_SUB;
      CLS_FUNCT: alu_ctl = funct_ctl;
      default:   alu_ctl = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_ctl_e          ctl,
  output logic [DATA_W-1:0] y,
  output logic              zero
);

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;
  logic              lt;

  assign sum  = a + b;
  assign diff = a - b;
  assign lt   = $signed(a) < $signed(b);

  always_comb begin
    unique case (ctl)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_NOR: y = ~(a | b);
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(DATA_W-1){1'b0}}, lt};
      default: y = sum;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DATA_W = 32,
  parameter int RA_W   = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RA_W-1:0]   raddr_a,
  input  logic [RA_W-1:0]   raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  localparam int DEPTH = 1 << RA_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Entry 0 is never written; its reads are forced to zero below
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : store[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : store[raddr_b];

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RA_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ir_write,
  input  logic              iord,
  input  logic              alu_src_a,
  input  logic [1:0]        alu_src_b,
  input  logic [1:0]        alu_op,
  input  logic [1:0]        pc_source,
  input  logic              pc_write,
  input  logic              pc_write_cond,
  input  logic              reg_dst,
  input  logic              mem_to_reg,
  input  logic              reg_write,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] alu_out_o,
  output logic              alu_zero
);

  localparam int IMM_W   = 16;
  localparam int JIDX_W  = 26;
  localparam int PCHI_W  = DATA_W - JIDX_W - 2;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int FN_W    = 6;

  // Holding registers
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] mdr_q;
  logic [DATA_W-1:0] opa_q;
  logic [DATA_W-1:0] opb_q;
  logic [DATA_W-1:0] aluout_q;

  // Instruction fields
  logic [RA_W-1:0]   rs_addr;
  logic [RA_W-1:0]   rt_addr;
  logic [RA_W-1:0]   rd_addr;
  logic [DATA_W-1:0] imm_sx;
  logic [DATA_W-1:0] imm_sx4;
  logic [DATA_W-1:0] jump_tgt;

  assign rs_addr  = ir_q[RS_LSB +: RA_W];
  assign rt_addr  = ir_q[RT_LSB +: RA_W];
  assign rd_addr  = ir_q[RD_LSB +: RA_W];
  assign imm_sx   = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sx4  = {imm_sx[DATA_W-3:0], 2'b00};
  assign jump_tgt = {pc_q[DATA_W-1 -: PCHI_W], ir_q[JIDX_W-1:0], 2'b00};

  // Register file
  logic [RA_W-1:0]   wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rs_data;
  logic [DATA_W-1:0] rt_data;

  assign wr_addr = reg_dst ? rd_addr : rt_addr;
  assign wr_data = mem_to_reg ? mdr_q : aluout_q;

  mc_regfile #(
    .DATA_W (DATA_W),
    .RA_W   (RA_W)
  ) u_rf (
    .clk     (clk),
    .we      (reg_write),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .raddr_a (rs_addr),
    .raddr_b (rt_addr),
    .rdata_a (rs_data),
    .rdata_b (rt_data)
  );

  // Arithmetic unit and its operand selection
  logic [DATA_W-1:0] alu_a;
  logic [DATA_W-1:0] alu_b;
  logic [DATA_W-1:0] alu_y;
  logic              alu_zero_w;
  alu_ctl_e          alu_ctl;

  assign alu_a = alu_src_a ? opa_q : pc_q;

  always_comb begin
    unique case (alu_src_b)
      SRCB_REG:   alu_b = opb_q;
      SRCB_FOUR:  alu_b = DATA_W'(4);
      SRCB_IMM:   alu_b = imm_sx;
      default:    alu_b = imm_sx4;
    endcase
  end

  mc_alu_ctrl u_actl (
    .alu_op  (alu_op),
    .funct   (ir_q[FN_W-1:0]),
    .alu_ctl (alu_ctl)
  );

  mc_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .a    (alu_a),
    .b    (alu_b),
    .ctl  (alu_ctl),
    .y    (alu_y),
    .zero (alu_zero_w)
  );

  // Next PC selection and qualified load
  logic [DATA_W-1:0] pc_next;
  logic              pc_load;

  always_comb begin
    unique case (pc_source)
      PCS_LIVE:  pc_next = alu_y;
      PCS_LATCH: pc_next = aluout_q;
      PCS_JUMP:  pc_next = jump_tgt;
      default:   pc_next = pc_q;
    endcase
  end

  assign pc_load = pc_write | (pc_write_cond & alu_zero_w);

  // Sequential state
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      opa_q    <= '0;
      opb_q    <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_load) begin
        pc_q <= pc_next;
      end
      if (ir_write) begin
        ir_q <= mem_rdata;
      end
      mdr_q    <= mem_rdata;
      opa_q    <= rs_data;
      opb_q    <= rt_data;
      aluout_q <= alu_y;
    end
  end

  assign mem_addr  = iord ? aluout_q : pc_q;
  assign mem_wdata = opb_q;
  assign pc_o      = pc_q;
  assign ir_o      = ir_q;
  assign alu_out_o = aluout_q;
  assign alu_zero  = alu_zero_w;

endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk
  import mc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RA_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              ir_write,
  input logic              pc_write,
  input logic              pc_write_cond,
  input logic              alu_zero,
  input logic [1:0]        alu_op,
  input alu_ctl_e          alu_ctl,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] ir_q,
  input logic [DATA_W-1:0] pc_q,
  input logic [DATA_W-1:0] aluout_q,
  input logic [DATA_W-1:0] alu_y,
  input logic [RA_W-1:0]   rs_addr,
  input logic [DATA_W-1:0] rs_data
);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && ir_q == '0 && aluout_q == '0));

  a_r5_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !ir_write |=> $stable(ir_q));

  a_r5_ir_load: assert property (@(posedge clk) disable iff (rst)
    ir_write |=> (ir_q == $past(mem_rdata)));

  a_r5_result_latch: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (aluout_q == $past(alu_y)));

  a_r4_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (!pc_write && !pc_write_cond) |=> $stable(pc_q));

  a_r4_pc_cond_blocked: assert property (@(posedge clk) disable iff (rst)
    (!pc_write && pc_write_cond && !alu_zero) |=> $stable(pc_q));

  a_r8_class_add: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 2'b00) |-> (alu_ctl == ALU_ADD));

  a_r8_class_sub: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 2'b01) |-> (alu_ctl == ALU_SUB));

  a_r10_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (rs_addr == '0) |-> (rs_data == '0));

endmodule

bind mc_datapath mc_datapath_chk #(
  .DATA_W (DATA_W),
  .RA_W   (RA_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ir_write      (ir_write),
  .pc_write      (pc_write),
  .pc_write_cond (pc_write_cond),
  .alu_zero      (alu_zero_w),
  .alu_op        (alu_op),
  .alu_ctl       (alu_ctl),
  .mem_rdata     (mem_rdata),
  .ir_q          (ir_q),
  .pc_q          (pc_q),
  .aluout_q      (aluout_q),
  .alu_y         (alu_y),
  .rs_addr       (rs_addr),
  .rs_data       (rs_data)
);

// File: tb/test_mc_datapath.sv
`timescale 1ns/1ps
module test_mc_datapath;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ir_write = 1'b0;
  logic        iord = 1'b0;
  logic        alu_src_a = 1'b0;
  logic [1:0]  alu_src_b = 2'b00;
  logic [1:0]  alu_op = 2'b00;
  logic [1:0]  pc_source = 2'b00;
  logic        pc_write = 1'b0;
  logic        pc_write_cond = 1'b0;
  logic        reg_dst = 1'b0;
  logic        mem_to_reg = 1'b0;
  logic        reg_write = 1'b0;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] pc_o;
  logic [31:0] ir_o;
  logic [31:0] alu_out_o;
  logic        alu_zero;

  always #2 clk = ~clk;

  // Shared memory model: 256 words, combinational read
  logic [31:0] mem [256];
  assign mem_rdata = mem[mem_addr[9:2]];

  mc_datapath i_mc_datapath (
    .clk           (clk),
    .rst           (rst),
    .ir_write      (ir_write),
    .iord          (iord),
    .alu_src_a     (alu_src_a),
    .alu_src_b     (alu_src_b),
    .alu_op        (alu_op),
    .pc_source     (pc_source),
    .pc_write      (pc_write),
    .pc_write_cond (pc_write_cond),
    .reg_dst       (reg_dst),
    .mem_to_reg    (mem_to_reg),
    .reg_write     (reg_write),
    .mem_rdata     (mem_rdata),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .pc_o          (pc_o),
    .ir_o          (ir_o),
    .alu_out_o     (alu_out_o),
    .alu_zero      (alu_zero)
  );

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [31:0] exp_pc = 32'h0;

  typedef struct packed {
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] y;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{6'h20, 32'd5,         32'd7,         32'd12},
    '{6'h20, 32'hFFFF_FFFF, 32'd1,         32'd0},
    '{6'h22, 32'd10,        32'd3,         32'd7},
    '{6'h22, 32'd3,         32'd10,        32'hFFFF_FFF9},
    '{6'h24, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F},
    '{6'h25, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFFF0_0FFF},
    '{6'h26, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFF00_0FF0},
    '{6'h27, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h000F_F000},
    '{6'h2A, 32'hFFFF_FFFF, 32'd1,         32'd1},
    '{6'h2A, 32'd1,         32'hFFFF_FFFF, 32'd0},
    '{6'h2A, 32'd5,         32'd5,         32'd0},
    '{6'h3F, 32'd2,         32'd3,         32'd5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr();
    ir_write = 0; iord = 0; alu_src_a = 0; alu_src_b = 0; alu_op = 0;
    pc_source = 0; pc_write = 0; pc_write_cond = 0; reg_dst = 0;
    mem_to_reg = 0; reg_write = 0;
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // Fetch and decode steps shared by all instructions
  task automatic fetch_decode(input logic [31:0] instr);
    mem[exp_pc[9:2]] = instr;
    clr(); ir_write = 1; pc_write = 1; alu_src_b = 2'd1;
    #1 chk("R2 fetch address is PC", mem_addr, exp_pc);
    tick();
    exp_pc = exp_pc + 32'd4;
    chk("R4 PC advanced by four", pc_o, exp_pc);
    chk("R5 IR loaded", ir_o, instr);
    clr(); alu_src_b = 2'd3;
    tick();
    chk("R3 decode target PC+imm*4", alu_out_o, exp_pc + {sx(instr[15:0]), 2'b00} - {sx(instr[15:0])[31:30], 32'h0});
    chk("R5 IR held without enable", ir_o, instr);
  endtask

  task automatic do_lw(input logic [4:0] rt, input logic [4:0] rs,
                       input logic [15:0] off, input logic [31:0] ea);
    fetch_decode(enc_i(6'b100011, rs, rt, off));
    clr(); alu_src_a = 1; alu_src_b = 2'd2;
    tick();
    chk("R3 effective address", alu_out_o, ea);
    clr(); iord = 1;
    #1 chk("R2 data address is result latch", mem_addr, ea);
    tick();
    clr(); reg_write = 1; mem_to_reg = 1;
    tick();
    clr();
  endtask

  task automatic do_sw(input logic [4:0] rt, input logic [4:0] rs,
                       input logic [15:0] off, input logic [31:0] ea,
                       input logic [31:0] expv, input string req);
    logic [31:0] a_s;
    logic [31:0] d_s;
    fetch_decode(enc_i(6'b101011, rs, rt, off));
    clr(); alu_src_a = 1; alu_src_b = 2'd2;
    tick();
    clr(); iord = 1;
    #1;
    a_s = mem_addr;
    d_s = mem_wdata;
    chk("R2 store address", a_s, ea);
    chk(req, d_s, expv);
    tick();
    mem[a_s[9:2]] = d_s;
    clr();
  endtask

  task automatic do_r(input logic [5:0] fn, input logic [4:0] rs, input logic [4:0] rt,
                      input logic [4:0] rd, input logic [31:0] y);
    fetch_decode(enc_r(rs, rt, rd, fn));
    clr(); alu_src_a = 1; alu_op = 2'd2;
    tick();
    chk($sformatf("R8 R9 function %h result", fn), alu_out_o, y);
    clr(); reg_write = 1; reg_dst = 1;
    tick();
    clr();
  endtask

  task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt,
                        input logic [15:0] off, input logic taken);
    logic [31:0] tgt;
    fetch_decode(enc_i(6'b000100, rs, rt, off));
    tgt = alu_out_o;
    clr(); alu_src_a = 1; alu_op = 2'd1; pc_source = 2'd1; pc_write_cond = 1;
    #1 chk("R9 zero flag on compare", {31'b0, alu_zero}, {31'b0, taken});
    tick();
    if (taken) exp_pc = tgt;
    chk(taken ? "R4 branch taken" : "R4 branch not taken", pc_o, exp_pc);
    clr();
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 32'h0;
    clr();
    rst = 1;
    @(negedge clk);
    repeat (3) tick();
    chk("R1 PC reset", pc_o, 32'h0);
    chk("R1 IR reset", ir_o, 32'h0);
    chk("R1 result latch reset", alu_out_o, 32'h0);
    rst = 0;

    // Table-driven register operations: load, operate, write back, store out
    for (int i = 0; i < NVEC; i++) begin
      mem[200] = VECS[i].a;
      mem[201] = VECS[i].b;
      do_lw(5'd1, 5'd0, 16'd800, 32'd800);
      do_lw(5'd2, 5'd0, 16'd804, 32'd804);
      do_r(VECS[i].fn, 5'd1, 5'd2, 5'd3, VECS[i].y);
      do_sw(5'd3, 5'd0, 16'd808, 32'd808, VECS[i].y, "R6 R7 store data from written register");
      chk("R7 result reached memory", mem[202], VECS[i].y);
    end

    // R10: write to register 0 discarded (r1=2, r2=3 from last vector)
    do_r(6'h20, 5'd1, 5'd2, 5'd0, 32'd5);
    do_sw(5'd0, 5'd0, 16'd812, 32'd812, 32'h0, "R10 register 0 reads zero");
    chk("R10 stored zero", mem[203], 32'h0);

    // R3: negative offset sign extension, load into rt field
    mem[204] = 32'd848;
    mem[210] = 32'hCAFE_F00D;
    do_lw(5'd5, 5'd0, 16'd816, 32'd816);
    do_lw(5'd6, 5'd5, 16'hFFF8, 32'd840);
    do_sw(5'd6, 5'd0, 16'd820, 32'd820, 32'hCAFE_F00D, "R3 R7 negative offset load");
    chk("R3 negative offset value stored", mem[205], 32'hCAFE_F00D);

    // R4: branches
    do_beq(5'd1, 5'd2, 16'd3, 1'b0);
    do_beq(5'd1, 5'd1, 16'd3, 1'b1);

    // R4: jump to word 120
    fetch_decode({6'b000010, 26'd120});
    clr(); pc_source = 2'd2; pc_write = 1;
    tick();
    exp_pc = {exp_pc[31:28], 26'd120, 2'b00};
    chk("R4 jump target", pc_o, exp_pc);
    clr();

    // R1: reset in mid-run
    rst = 1;
    tick();
    chk("R1 PC cleared mid-run", pc_o, 32'h0);
    chk("R1 IR cleared mid-run", ir_o, 32'h0);
    rst = 0;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule